// File: doc/BRIEF.md
# Matrix-Based True LRU Tracker

This block keeps the exact least-recently-used order of a small group of cache entries, either one set of a set-associative cache or a whole fully associative cache. The default is four entries, and the count is a parameter. It holds one older-than relation for each pair of entries. When an entry is accessed, it becomes newer than every other entry. The entry that is older than all the others is reported as the replacement victim.

The cache controller pulses the access strobe with the index of the entry it has just used. It reads the victim outputs whenever it has to allocate. The victim outputs are combinational from the stored relations. The block does not handle tags, data, hit or miss detection, or allocation.

Top module: `lru_matrix_tracker`

## Requirements
- R1: At every cycle after reset, exactly one bit of `victim_oh` is set.
- R2: Reset is synchronous and active low. While `rst_n` is low at a rising edge, the order is reloaded so that entry WAYS-1 is the oldest and entry 0 is the newest. After that edge, `victim_idx` equals WAYS-1.
- R3: A valid access to entry k at a rising edge makes k the newest entry. From the next cycle on, k is not the victim, unless WAYS-1 other distinct entries have been accessed after it.
- R4: The victim is the entry whose most recent access lies furthest in the past. Entries that have not been accessed since reset are ranked by the reset order.
- R5: At an edge where `acc_valid` is low, the stored order does not change, whatever value `acc_idx` has.
- R6: The victim outputs show the order as it stood before an access on the same edge. An access becomes visible only after that edge.
- R7: Accessing the same entry on consecutive edges leaves the order unchanged after the first of those accesses.
- R8: With WAYS=4, the access sequence 2, 1, 3, 0 after reset gives the victims 3, 3, 0, 2 after each access in turn.
- R9: `victim_idx` is the binary position of the set bit in `victim_oh`. Bit i of `victim_oh` stands for entry i.
- R10: The tracker works for every WAYS from 2 to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access happens on this edge |
| acc_idx | input | max(1,clog2(WAYS)) | Index of the accessed entry |
| victim_idx | output | max(1,clog2(WAYS)) | Binary index of the least recently used entry |
| victim_oh | output | WAYS | One-hot vector of the least recently used entry |

## Verification
The bench instantiates the tracker three times, with WAYS of 2, 4 and 8. All three instances share one access stream, and each instance takes the access index modulo its own size. The two-entry instance exercises the smallest case, in which the pair matrix has a single stored bit. The eight-entry instance exercises long orderings in which an entry must stay un-accessed for seven distinct accesses before it becomes the victim. The four-entry instance runs the fixed access sequence from R8. In a random stream that includes idle cycles, repeated accesses and a reset in the middle of the run, each instance is compared with an ordered list kept by the bench.

// File: rtl/lru_pkg.sv
// Package lru_pkg
// Shared helpers for the LRU tracker.
// Assumes: entry counts of at least 2.
package lru_pkg;

    // Index width for an entry count, never less than one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru_age_matrix.sv
// Module lru_age_matrix
// Stores the older-than relation for every pair i<j as one flop, and
// derives the lower triangle by inversion. The diagonal is constant 1.
// older_flat[i*WAYS+j] = 1 means entry i is older than entry j.
// Assumes: acc_idx < WAYS whenever acc_valid is high.
module lru_age_matrix
    import lru_pkg::*;
#(
    parameter  int WAYS  = 4,
    localparam int IDX_W = idx_w(WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [IDX_W-1:0]     acc_idx,
    output logic [WAYS*WAYS-1:0] older_flat
);

    for (genvar gi = 0; gi < WAYS; gi++) begin : g_row
        for (genvar gj = 0; gj < WAYS; gj++) begin : g_col
            if (gi == gj) begin : g_diag
                assign older_flat[gi*WAYS+gj] = 1'b1;
            end else if (gi < gj) begin : g_pair
                logic rel_q;
                // Pair flop: reset makes the higher index older; an access clears its row, sets its column.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        rel_q <= 1'b0;
                    else if (acc_valid && acc_idx == IDX_W'(gi))
                        rel_q <= 1'b0;
                    else if (acc_valid && acc_idx == IDX_W'(gj))
                        rel_q <= 1'b1;
                end
                assign older_flat[gi*WAYS+gj] = rel_q;
                assign older_flat[gj*WAYS+gi] = ~rel_q;
            end
        end
    end

    // Row view for the checks below.
    logic [WAYS-1:0] row_v [WAYS];
    for (genvar gr = 0; gr < WAYS; gr++) begin : g_rowv
        assign row_v[gr] = older_flat[gr*WAYS +: WAYS];
    end

    // R5: without a valid access the relations hold
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(older_flat));

    // R3: the accessed row is older than nobody except itself
    p_row_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> row_v[$past(acc_idx)] == (WAYS'(1) << $past(acc_idx)));

    // R7: a repeated access changes nothing
    p_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(acc_valid) && $past(rst_n) && acc_idx == $past(acc_idx))
        |=> $stable(older_flat));

endmodule

// File: rtl/lru_victim_find.sv
// Module lru_victim_find
// Flags the entry whose whole row is ones, that is, the entry older than all others.
// Assumes: the relation matrix is a consistent total order.
module lru_victim_find #(
    parameter int WAYS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WAYS*WAYS-1:0] older_flat,
    output logic [WAYS-1:0]      victim_oh
);

    for (genvar gi = 0; gi < WAYS; gi++) begin : g_and
        // Row reduction: entry gi is older than every entry.
        assign victim_oh[gi] = &older_flat[gi*WAYS +: WAYS];
    end

    // R1: exactly one entry is the victim
    p_single_victim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(victim_oh) == 1);

endmodule

// File: rtl/lru_onehot_enc.sv
// Module lru_onehot_enc
// Converts a one-hot vector to its binary position.
// Assumes: at most one input bit is set.
module lru_onehot_enc
    import lru_pkg::*;
#(
    parameter  int WAYS  = 4,
    localparam int IDX_W = idx_w(WAYS)
) (
    input  logic [WAYS-1:0]  onehot,
    output logic [IDX_W-1:0] index
);

    // OR together the positions of all set bits.
    always_comb begin
        index = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (onehot[i]) index = index | IDX_W'(i);
        end
    end

endmodule

// File: rtl/lru_matrix_tracker.sv
// Module lru_matrix_tracker
// True-LRU tracker for WAYS entries built on a pairwise age matrix.
// The victim outputs are combinational from the stored order.
// Assumes: 2 <= WAYS <= 8 and acc_idx < WAYS while acc_valid is high.
module lru_matrix_tracker
    import lru_pkg::*;
#(
    parameter  int WAYS  = 4,
    localparam int IDX_W = idx_w(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    output logic [IDX_W-1:0] victim_idx,
    output logic [WAYS-1:0]  victim_oh
);

    logic [WAYS*WAYS-1:0] older_flat;

    lru_age_matrix #(.WAYS(WAYS)) u_matrix (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_idx    (acc_idx),
        .older_flat (older_flat)
    );

    lru_victim_find #(.WAYS(WAYS)) u_find (
        .clk        (clk),
        .rst_n      (rst_n),
        .older_flat (older_flat),
        .victim_oh  (victim_oh)
    );

    lru_onehot_enc #(.WAYS(WAYS)) u_enc (
        .onehot (victim_oh),
        .index  (victim_idx)
    );

    // R2: reset leaves the highest index as the victim
    p_reset_order_r2: assert property (@(posedge clk)
        !rst_n |=> victim_idx == IDX_W'(WAYS - 1));

    // R3: the entry just accessed is not the victim
    p_mru_not_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !victim_oh[$past(acc_idx)]);

    // R9: the index points at the set bit
    p_enc_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        victim_oh[victim_idx]);

endmodule

// File: tb/lru_matrix_tracker_tb.sv
`timescale 1ns/1ps
module lru_matrix_tracker_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [0:0] idx2 = '0;
    logic [1:0] idx4 = '0;
    logic [2:0] idx8 = '0;
    logic [0:0] vi2;
    logic [1:0] vi4;
    logic [2:0] vi8;
    logic [1:0] oh2;
    logic [3:0] oh4;
    logic [7:0] oh8;

    lru_matrix_tracker #(.WAYS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(idx4),
        .victim_idx(vi4), .victim_oh(oh4));
    lru_matrix_tracker #(.WAYS(2)) u_dut_w2 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(idx2),
        .victim_idx(vi2), .victim_oh(oh2));
    lru_matrix_tracker #(.WAYS(8)) u_dut_w8 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(idx8),
        .victim_idx(vi8), .victim_oh(oh8));

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference: ord[d][0] is the oldest entry of instance d.
    int sz [3] = '{2, 4, 8};
    int ord [3][8];

    typedef struct {
        int    e [3];
        string req;
    } exp_t;
    exp_t pend [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ref_reset();
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < sz[d]; p++) ord[d][p] = sz[d] - 1 - p;
    endtask

    task automatic ref_touch(input int d, input int k);
        int pos = 0;
        for (int p = 0; p < sz[d]; p++) if (ord[d][p] == k) pos = p;
        for (int p = pos; p < sz[d] - 1; p++) ord[d][p] = ord[d][p+1];
        ord[d][sz[d]-1] = k;
    endtask

    task automatic push_exp(input string req);
        exp_t it;
        for (int d = 0; d < 3; d++) it.e[d] = ord[d][0];
        it.req = req;
        pend.push_back(it);
    endtask

    // Compare outputs of all three instances with expected victims.
    task automatic cmp_all(input int e0, input int e1, input int e2, input string req);
        check(int'(vi2) == e0 && oh2 == (2'b1 << e0), {req, " w2"}, int'(vi2), e0);
        check(int'(vi4) == e1 && oh4 == (4'b1 << e1), {req, " w4"}, int'(vi4), e1);
        check(int'(vi8) == e2 && oh8 == (8'b1 << e2), {req, " w8"}, int'(vi8), e2);
    endtask

    // Driver: one cycle of stimulus, with a same-edge check of the old order.
    task automatic drive(input bit v, input int a, input string req);
        @(negedge clk);
        rst_n     = 1'b1;
        acc_valid = v;
        idx2 = 1'(a % 2);
        idx4 = 2'(a % 4);
        idx8 = 3'(a % 8);
        #1;
        if (v) cmp_all(ord[0][0], ord[1][0], ord[2][0], "R6 pre-update");
        if (v) begin
            ref_touch(0, a % 2);
            ref_touch(1, a % 4);
            ref_touch(2, a % 8);
        end
        push_exp(req);
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b1;
        idx2 = '0; idx4 = 2'd3; idx8 = 3'd5;
        ref_reset();
        push_exp(req);
    endtask

    // Monitor: after each edge, pop the expected victims and compare.
    always @(posedge clk) begin
        exp_t it;
        #2;
        if (pend.size() > 0) begin
            it = pend.pop_front();
            cmp_all(it.e[0], it.e[1], it.e[2], it.req);
        end
    end

    initial begin
        int a;
        ref_reset();
        do_reset("R2 reset order");
        do_reset("R2 reset order");
        // R8: fixed sequence on the four-entry instance
        drive(1, 2, "R8 after 2");
        drive(1, 1, "R8 after 2,1");
        drive(1, 3, "R8 after 2,1,3");
        drive(1, 0, "R8 after 2,1,3,0");
        @(negedge clk); #1;
        check(int'(vi4) == 2, "R8 final victim", int'(vi4), 2);
        // R5: idle cycles with changing index
        drive(0, 5, "R5 idle");
        drive(0, 6, "R5 idle");
        drive(0, 1, "R5 idle");
        // R7: repeats
        drive(1, 6, "R7 repeat first");
        drive(1, 6, "R7 repeat");
        drive(1, 6, "R7 repeat");
        // R3/R4: walk every entry so the eight-entry victim cycles
        for (int k = 0; k < 8; k++) drive(1, k, "R3 sweep");
        // R2: reset in mid-run
        do_reset("R2 mid reset");
        drive(0, 0, "R2 after reset hold");
        // R4/R10: random stream
        for (int n = 0; n < 3000; n++) begin
            a = $urandom_range(0, 7);
            if ($urandom_range(0, 9) < 2) drive(0, a, "R5 random idle");
            else if ($urandom_range(0, 9) < 2) begin
                drive(1, a, "R7 random repeat");
                drive(1, a, "R7 random repeat");
            end else drive(1, a, "R4 random");
        end
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule